// File: doc/BRIEF.md
# DMA Channel Command and Status Gating

This block keeps the status flags of each channel of a multi-channel DMA controller and decides whether software commands are allowed to start work. A shared command port carries three commands: a controller-wide reset, a set-software-request and a start-chain, the last two aimed at one channel. From the flags it decides when to issue a one-cycle start-chain request to the reload sequencer and a one-cycle begin-transfer request to the data mover. The sequencer and the mover report back through strobes: chain address loaded, chaining finished (optionally with the software request bit loaded), and termination (optionally with an interrupt).

Each channel holds an interrupt vector register and a two-entry interrupt save stack. When a termination raises an interrupt, the current vector and a termination code are copied into the stack. This lets a new vector be loaded, and a second operation run, before the first interrupt is acknowledged. A second pending interrupt blocks further commands on that channel until an acknowledge drains it. All flag updates are registered. A command is judged on the flag values held before the clock edge that samples it.

Top module: `dma_cmd_gate`

## Requirements
- R1: After rst_n low, or a reset command (cmd_op = 0, any cmd_ch), every channel has chaining, active, irq and irq2 clear, noaddr and parked set, swreq clear, and ack_vec and ack_code zero. The status bits of channel c are status_o[6c+5:6c] = {parked, noaddr, irq2, irq, active, chaining}, so the reset value is 6'h30.
- R2: A set-software-request command (cmd_op = 1) sets swreq of channel cmd_ch at the sampling edge. Other channels are unaffected.
- R3: begin_xfer_o[c] pulses for one cycle on the cycle after one in which swreq=1, irq2=0, parked=0, chaining=0 and active=0. At that edge active sets and swreq clears. While irq2 or parked is set, no transfer begins.
- R4: A start-chain command (cmd_op = 2) is accepted only when irq2=0 and noaddr=0. Acceptance gives a one-cycle start_chain_o pulse after the sampling edge, sets chaining and clears parked. A refused command has no effect on any output. cmd_op = 3 has no effect.
- R5: A chain-address-loaded strobe clears noaddr.
- R6: A chain-done strobe clears chaining. When it comes with chain_swreq, swreq is set, so the transfer begins by R3 without another command.
- R7: A termination strobe clears active and sets parked. When it comes with term_ie, an interrupt is recorded holding the vector register and term_code. With no interrupt already pending, it sets irq and appears on ack_vec/ack_code.
- R8: An interrupt recorded while irq is set sets irq2 and leaves ack_vec/ack_code unchanged. One raised while irq2 is set is dropped.
- R9: An acknowledge strobe on a channel with irq set removes the entry shown on ack_vec/ack_code. A pending second interrupt then moves up: irq stays set, irq2 clears, and its vector and code appear. With no second interrupt, irq clears and the outputs read zero.
- R10: A vector-load strobe writes vec_data_i into the channel's vector register. A vector loaded after an interrupt has been recorded does not change that recorded vector, but is used by the next one.
- R11: A command in the same cycle as a flag-clearing strobe sees the old flag. In particular, a start-chain in the cycle of the acknowledge that clears irq2 is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 reset, 1 set software request, 2 start chain, 3 no effect |
| cmd_ch_i | input | CH_W | Target channel of the command |
| iack_i | input | NUM_CH | Interrupt acknowledge per channel |
| chaddr_load_i | input | NUM_CH | Chain address register loaded |
| chain_done_i | input | NUM_CH | Chain reload finished |
| chain_swreq_i | input | NUM_CH | Software request bit loaded by the finished chain |
| term_i | input | NUM_CH | Operation terminated |
| term_ie_i | input | NUM_CH | Termination raises an interrupt |
| term_code_i | input | NUM_CH*CODE_W | Termination code per channel |
| vec_load_i | input | NUM_CH | Load vector register |
| vec_data_i | input | VEC_W | Vector value for vec_load_i |
| status_o | output | NUM_CH*6 | Per-channel flags {parked, noaddr, irq2, irq, active, chaining} |
| swreq_o | output | NUM_CH | Software request pending |
| start_chain_o | output | NUM_CH | Start-chain request to the reload sequencer |
| begin_xfer_o | output | NUM_CH | Begin-transfer request |
| ack_vec_o | output | NUM_CH*VEC_W | Vector of the oldest pending interrupt |
| ack_code_o | output | NUM_CH*CODE_W | Code of the oldest pending interrupt |

## Verification
The start-chain command and the interrupt acknowledge can fall in the same cycle. The acknowledge clears the second-pending flag that gates the command. The bench fills both interrupt entries, then drives a start-chain and an acknowledge on the same edge. It expects no start_chain_o pulse, irq2 clear and the second entry on ack_code_o. It then repeats the command alone and expects it to be accepted. A vector load in the cycle after an interrupt is recorded is also checked: ack_vec_o must keep the old vector.

// File: rtl/dmagate_pkg.sv
package dmagate_pkg;
  typedef enum logic [1:0] {
    OP_RESET  = 2'd0,
    OP_SETREQ = 2'd1,
    OP_START  = 2'd2,
    OP_NONE   = 2'd3
  } cmd_op_e;

  localparam int FLAG_N = 6;

  typedef struct packed {
    logic parked;
    logic noaddr;
    logic irq2;
    logic irq;
    logic active;
    logic chaining;
  } chan_flags_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [CH_W-1:0]   cmd_ch_i,
  output logic              clr_all_o,
  output logic [NUM_CH-1:0] setreq_o,
  output logic [NUM_CH-1:0] start_o
);
  import dmagate_pkg::*;

  cmd_op_e op;
  assign op = cmd_op_e'(cmd_op_i);
  assign clr_all_o = cmd_valid_i && (op == OP_RESET);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    logic hit;
    assign hit         = cmd_valid_i && (int'(cmd_ch_i) == c);
    assign setreq_o[c] = hit && (op == OP_SETREQ);
    assign start_o[c]  = hit && (op == OP_START);
  end
endmodule

// File: rtl/irq_stack.sv
module irq_stack #(
  parameter int VEC_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [VEC_W-1:0]  push_vec_i,
  input  logic [CODE_W-1:0] push_code_i,
  input  logic              pop_i,
  output logic [VEC_W-1:0]  head_vec_o,
  output logic [CODE_W-1:0] head_code_o,
  output logic              pend1_o,
  output logic              pend2_o
);
  localparam int ENT_W = VEC_W + CODE_W;

  logic [ENT_W-1:0] slot0, slot1, new_ent;
  logic [1:0]       cnt;
  logic             pop_ok, push_ok;

  assign new_ent = {push_vec_i, push_code_i};
  assign pop_ok  = pop_i && (cnt != 2'd0);
  assign push_ok = push_i && (cnt != 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
      cnt   <= 2'd0;
    end else if (clr_i) begin
      slot0 <= '0;
      slot1 <= '0;
      cnt   <= 2'd0;
    end else begin
      unique case ({pop_ok, push_ok})
        2'b10: begin
          slot0 <= slot1;
          slot1 <= '0;
          cnt   <= cnt - 2'd1;
        end
        2'b01: begin
          if (cnt == 2'd0) slot0 <= new_ent;
          else             slot1 <= new_ent;
          cnt <= cnt + 2'd1;
        end
        2'b11: begin
          slot0 <= new_ent;
        end
        default: ;
      endcase
    end
  end

  assign head_vec_o  = slot0[ENT_W-1:CODE_W];
  assign head_code_o = slot0[CODE_W-1:0];
  assign pend1_o     = (cnt != 2'd0);
  assign pend2_o     = (cnt == 2'd2);

  // R8
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pend2_o && !pop_i && !clr_i) |=> ($stable(head_vec_o) && pend2_o));

  // R9
  pop_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && pend2_o && !clr_i) |=> (pend1_o && !pend2_o));
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl #(
  parameter int VEC_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              setreq_i,
  input  logic              start_i,
  input  logic              iack_i,
  input  logic              chaddr_load_i,
  input  logic              chain_done_i,
  input  logic              chain_swreq_i,
  input  logic              term_i,
  input  logic              term_ie_i,
  input  logic [CODE_W-1:0] term_code_i,
  input  logic              vec_load_i,
  input  logic [VEC_W-1:0]  vec_data_i,
  output dmagate_pkg::chan_flags_t flags_o,
  output logic              swreq_o,
  output logic              start_chain_o,
  output logic              begin_xfer_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic [CODE_W-1:0] ack_code_o
);
  logic             chaining, active, noaddr, parked, swreq;
  logic             start_q, begin_q;
  logic [VEC_W-1:0] vec_q;
  logic             irq, irq2;
  logic             start_ok, begin_ok;

  assign start_ok = start_i && !irq2 && !noaddr;
  assign begin_ok = swreq && !irq2 && !parked && !chaining && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chaining <= 1'b0;
      active   <= 1'b0;
      noaddr   <= 1'b1;
      parked   <= 1'b1;
      swreq    <= 1'b0;
      start_q  <= 1'b0;
      begin_q  <= 1'b0;
      vec_q    <= '0;
    end else if (clr_i) begin
      chaining <= 1'b0;
      active   <= 1'b0;
      noaddr   <= 1'b1;
      parked   <= 1'b1;
      swreq    <= 1'b0;
      start_q  <= 1'b0;
      begin_q  <= 1'b0;
      vec_q    <= '0;
    end else begin
      start_q <= start_ok;
      begin_q <= begin_ok;
      if (start_ok)          chaining <= 1'b1;
      else if (chain_done_i) chaining <= 1'b0;
      if (begin_ok)          active <= 1'b1;
      else if (term_i)       active <= 1'b0;
      if (term_i)            parked <= 1'b1;
      else if (start_ok)     parked <= 1'b0;
      if (chaddr_load_i)     noaddr <= 1'b0;
      swreq <= (swreq && !begin_ok) || setreq_i || (chain_done_i && chain_swreq_i);
      if (vec_load_i)        vec_q <= vec_data_i;
    end
  end

  irq_stack #(.VEC_W(VEC_W), .CODE_W(CODE_W)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .push_i     (term_i && term_ie_i),
    .push_vec_i (vec_q),
    .push_code_i(term_code_i),
    .pop_i      (iack_i),
    .head_vec_o (ack_vec_o),
    .head_code_o(ack_code_o),
    .pend1_o    (irq),
    .pend2_o    (irq2)
  );

  assign flags_o = '{parked: parked, noaddr: noaddr, irq2: irq2, irq: irq,
                     active: active, chaining: chaining};
  assign swreq_o       = swreq;
  assign start_chain_o = start_q;
  assign begin_xfer_o  = begin_q;

  // R1
  clr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (noaddr && parked && !chaining && !active && !swreq && !irq));

  // R3
  begin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    begin_xfer_o |-> ($past(!irq2 && !parked) && active && !$past(active)));

  // R4
  start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clr_i && (irq2 || noaddr)) |=> !start_chain_o);

  // R5
  chaddr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chaddr_load_i && !clr_i) |=> !noaddr);
endmodule

// File: rtl/dma_cmd_gate.sv
module dma_cmd_gate #(
  parameter int NUM_CH = 2,
  parameter int VEC_W  = 8,
  parameter int CODE_W = 3,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid_i,
  input  logic [1:0]               cmd_op_i,
  input  logic [CH_W-1:0]          cmd_ch_i,
  input  logic [NUM_CH-1:0]        iack_i,
  input  logic [NUM_CH-1:0]        chaddr_load_i,
  input  logic [NUM_CH-1:0]        chain_done_i,
  input  logic [NUM_CH-1:0]        chain_swreq_i,
  input  logic [NUM_CH-1:0]        term_i,
  input  logic [NUM_CH-1:0]        term_ie_i,
  input  logic [NUM_CH*CODE_W-1:0] term_code_i,
  input  logic [NUM_CH-1:0]        vec_load_i,
  input  logic [VEC_W-1:0]         vec_data_i,
  output logic [NUM_CH*6-1:0]      status_o,
  output logic [NUM_CH-1:0]        swreq_o,
  output logic [NUM_CH-1:0]        start_chain_o,
  output logic [NUM_CH-1:0]        begin_xfer_o,
  output logic [NUM_CH*VEC_W-1:0]  ack_vec_o,
  output logic [NUM_CH*CODE_W-1:0] ack_code_o
);
  import dmagate_pkg::*;

  logic              clr_all;
  logic [NUM_CH-1:0] setreq, start;

  cmd_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_ch_i   (cmd_ch_i),
    .clr_all_o  (clr_all),
    .setreq_o   (setreq),
    .start_o    (start)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_flags_t fl;
    chan_ctrl #(.VEC_W(VEC_W), .CODE_W(CODE_W)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (clr_all),
      .setreq_i     (setreq[c]),
      .start_i      (start[c]),
      .iack_i       (iack_i[c]),
      .chaddr_load_i(chaddr_load_i[c]),
      .chain_done_i (chain_done_i[c]),
      .chain_swreq_i(chain_swreq_i[c]),
      .term_i       (term_i[c]),
      .term_ie_i    (term_ie_i[c]),
      .term_code_i  (term_code_i[c*CODE_W +: CODE_W]),
      .vec_load_i   (vec_load_i[c]),
      .vec_data_i   (vec_data_i),
      .flags_o      (fl),
      .swreq_o      (swreq_o[c]),
      .start_chain_o(start_chain_o[c]),
      .begin_xfer_o (begin_xfer_o[c]),
      .ack_vec_o    (ack_vec_o[c*VEC_W +: VEC_W]),
      .ack_code_o   (ack_code_o[c*CODE_W +: CODE_W])
    );
    assign status_o[c*FLAG_N +: FLAG_N] = fl;

    // R7
    term_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (term_i[c] && !clr_all) |=> (fl.parked && !fl.active));
  end
endmodule

// File: tb/sim_dma_cmd_gate.sv
`timescale 1ns/100ps
module sim_dma_cmd_gate;
  localparam int NCH = 2, VW = 8, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic cmd_ch = 1'b0;
  logic [NCH-1:0] iack = '0, chaddr = '0, cdone = '0, cswreq = '0, term = '0, tie = '0, vload = '0;
  logic [NCH*CW-1:0] tcode = '0;
  logic [VW-1:0] vdata = '0;
  logic [NCH*6-1:0] status;
  logic [NCH-1:0] swreq, startc, beginx;
  logic [NCH*VW-1:0] avec;
  logic [NCH*CW-1:0] acode;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  dma_cmd_gate #(.NUM_CH(NCH), .VEC_W(VW), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_ch_i(cmd_ch),
    .iack_i(iack), .chaddr_load_i(chaddr), .chain_done_i(cdone), .chain_swreq_i(cswreq),
    .term_i(term), .term_ie_i(tie), .term_code_i(tcode), .vec_load_i(vload), .vec_data_i(vdata),
    .status_o(status), .swreq_o(swreq), .start_chain_o(startc), .begin_xfer_o(beginx),
    .ack_vec_o(avec), .ack_code_o(acode));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; cmd_op = 2'd3; iack = '0; chaddr = '0; cdone = '0;
    cswreq = '0; term = '0; tie = '0; vload = '0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic ch);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch;
  endtask

  task automatic fin();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int st(int c); return int'(status[c*6 +: 6]); endfunction
  function automatic int av(int c); return int'(avec[c*VW +: VW]); endfunction
  function automatic int ac(int c); return int'(acode[c*CW +: CW]); endfunction

  // monitor: pulses are popped against the expected queue (kind*16 + channel)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (startc[c]) begin
          if (exp_q.size() == 0) chk("R4 unexpected start_chain", 16 + c, -1);
          else chk("R4 start_chain pulse", 16 + c, exp_q.pop_front());
        end
        if (beginx[c]) begin
          if (exp_q.size() == 0) chk("R3 unexpected begin_xfer", 32 + c, -1);
          else chk("R3 begin_xfer pulse", 32 + c, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    fin();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 status ch0", st(0), 'h30);
    chk("R1 status ch1", st(1), 'h30);
    chk("R1 ack_vec", av(0), 0);
    // R2 set software request; R3 blocked while parked
    cmd(2'd1, 1'b0); step();
    chk("R2 swreq ch0", int'(swreq[0]), 1);
    chk("R2 swreq ch1 untouched", int'(swreq[1]), 0);
    step(); step();
    chk("R3 blocked while parked", st(0), 'h30);
    // R4 refused while noaddr; opcode 3 no effect
    cmd(2'd2, 1'b0); step();
    cmd(2'd3, 1'b0); step();
    chk("R4 start refused noaddr", st(0), 'h30);
    // R5
    chaddr[0] = 1'b1; step();
    chk("R5 noaddr cleared", st(0), 'h10 & 'h00 | 'h20);
    // R4 accepted
    exp_q.push_back(16); cmd(2'd2, 1'b0); step();
    chk("R4 chaining set parked clear", st(0), 'h01);
    chk("R2 ch1 isolated", st(1), 'h30);
    // R6 chain done, then R3 begin from pending request
    exp_q.push_back(32); cdone[0] = 1'b1; step();
    chk("R6 chaining cleared", st(0), 'h00);
    step();
    chk("R3 active after begin", st(0), 'h02);
    chk("R3 swreq consumed", int'(swreq[0]), 0);
    // R10 vector load, R7 termination with interrupt
    vload[0] = 1'b1; vdata = 8'hA5; step();
    term[0] = 1'b1; tie[0] = 1'b1; tcode[2:0] = 3'd3; step();
    chk("R7 status after term", st(0), 'h24);
    chk("R7 saved vector", av(0), 'hA5);
    chk("R7 saved code", ac(0), 3);
    vload[0] = 1'b1; vdata = 8'h5A; step();
    chk("R10 saved vector kept", av(0), 'hA5);
    // second operation: R6 chain-loaded software request
    exp_q.push_back(16); cmd(2'd2, 1'b0); step();
    chk("R4 start with irq set", st(0), 'h05);
    exp_q.push_back(32); cdone[0] = 1'b1; cswreq[0] = 1'b1; step();
    chk("R6 swreq from chain", int'(swreq[0]), 1);
    step();
    chk("R6 auto begin", st(0), 'h06);
    term[0] = 1'b1; tie[0] = 1'b1; tcode[2:0] = 3'd5; step();
    chk("R8 irq2 set", st(0), 'h2C);
    chk("R8 head unchanged", av(0), 'hA5);
    // R8 third interrupt dropped
    term[0] = 1'b1; tie[0] = 1'b1; tcode[2:0] = 3'd7; step();
    chk("R8 full keeps head code", ac(0), 3);
    // R9 acknowledges
    iack[0] = 1'b1; step();
    chk("R9 moved up status", st(0), 'h24);
    chk("R9 second vector", av(0), 'h5A);
    chk("R9 second code", ac(0), 5);
    iack[0] = 1'b1; step();
    chk("R9 drained status", st(0), 'h20);
    chk("R9 drained vector", av(0), 0);
    // R11 start chain in the same cycle as the acknowledge clearing irq2
    term[0] = 1'b1; tie[0] = 1'b1; tcode[2:0] = 3'd1; step();
    term[0] = 1'b1; tie[0] = 1'b1; tcode[2:0] = 3'd2; step();
    chk("R8 two pending", st(0), 'h2C);
    cmd(2'd2, 1'b0); iack[0] = 1'b1; step();
    chk("R11 start refused on old irq2", st(0), 'h24);
    chk("R11 head after pop", ac(0), 2);
    exp_q.push_back(16); cmd(2'd2, 1'b0); step();
    chk("R11 start accepted afterwards", st(0), 'h05);
    cdone[0] = 1'b1; step();
    // R1 reset command aimed at ch1 clears both channels
    cmd(2'd1, 1'b1); step();
    chk("R2 swreq ch1", int'(swreq[1]), 1);
    cmd(2'd0, 1'b1); step();
    chk("R1 reset cmd ch0", st(0), 'h30);
    chk("R1 reset cmd ack", av(0), 0);
    chk("R1 reset cmd swreq", int'(swreq), 0);
    step(); step();
    chk("R3 no missing pulses", exp_q.size(), 0);
    fin();
  end
endmodule